// File: doc/BRIEF.md
# Transfer speed fallback controller

This block watches a storage link for transmission errors and lowers the transfer mode when errors come too often. Errors arrive as single-cycle pulses. A slow time-base tick marks out a fixed observation window. If more than a set number of errors fall inside one window, the block moves the link one step down an ordered ladder of modes.

The ladder has three families. On a serial link it first steps through the serial PHY generations, from fastest to slowest. It then steps through the UDMA modes from the highest down to UDMA0. After that come PIO4 and then PIO3. PIO3 is the floor. When a further step is asked for at the floor, the mode stays where it is and a sticky warning is raised, and the block keeps running. On a parallel link the PHY generations are skipped.

Each step is announced by a single-cycle request pulse, and the new mode code is already on the output in that same cycle. Some other agent applies the new mode.

Top module: `xfer_fallback`

## Requirements
- R1: While `rst` is high at a clock edge, `cur_mode` loads `boot_mode`, and `mode_req` and `floor_warn` go low. A `boot_mode` above the last code loads the PIO3 code. A PHY-generation code loads the top UDMA code when `sata_link` is low.
- R2: Mode codes are numbered as follows, with S = `SATA_GENS` and U = `UDMA_MODES`. Codes 0..S-1 are the PHY generations, fastest first. Codes S..S+U-1 are UDMA U-1 down to UDMA0. Code S+U is PIO4 and code S+U+1 is PIO3. Each downgrade raises the code.
- R3: Up to `ERR_LIMIT` errors within one window leave `cur_mode` unchanged. The next error within the same window requests a downgrade.
- R4: A downgrade raises `mode_req` for exactly the one cycle after the clock edge that sampled the triggering error. In that cycle `cur_mode` already holds the next code.
- R5: The window closes on the `WINDOW_TICKS`-th tick since the window opened. Errors counted before it closes no longer count afterwards.
- R6: After every downgrade request, including one refused at the floor, the error count is zero and a fresh window opens.
- R7: The step after the slowest PHY generation is the top UDMA code. UDMA0 steps to PIO4, and PIO4 steps to PIO3. While `sata_link` is low, a PHY-generation code steps straight to the top UDMA code.
- R8: A downgrade requested at PIO3 leaves `cur_mode` unchanged and keeps `mode_req` low. It sets `floor_warn`, which stays high until reset.
- R9: An error in the same cycle as the tick that closes a window counts as the first error of the new window. It never triggers a downgrade.
- R10: A reset in mid-operation clears the warning and the partial error count, and reloads the mode from `boot_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_err | input | 1 | One-cycle pulse per transmission error |
| time_tick | input | 1 | One-cycle time-base tick |
| sata_link | input | 1 | High when the link is serial |
| boot_mode | input | MODE_W | Mode code loaded at reset |
| cur_mode | output | MODE_W | Current mode code |
| mode_req | output | 1 | One-cycle pulse when a new mode is requested |
| floor_warn | output | 1 | Sticky flag: a downgrade was wanted at PIO3 |

## Verification
Two events can fall in the same cycle: an error pulse and the tick that closes the window. The bench fills a window to its last tick with errors one short of the trigger. It then drives the error and the closing tick together and checks that no request follows. Two more errors are then needed before the downgrade appears. If the count had simply carried over, the request would have come one error earlier.

// File: rtl/xfer_fallback.sv
module xfer_fallback #(
  parameter int SATA_GENS    = 3,
  parameter int UDMA_MODES   = 7,
  parameter int ERR_LIMIT    = 3,
  parameter int WINDOW_TICKS = 900,
  localparam int NMODES = SATA_GENS + UDMA_MODES + 2,
  localparam int MODE_W = $clog2(NMODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_err,
  input  logic              time_tick,
  input  logic              sata_link,
  input  logic [MODE_W-1:0] boot_mode,
  output logic [MODE_W-1:0] cur_mode,
  output logic              mode_req,
  output logic              floor_warn
);
  localparam int LAST  = NMODES - 1;
  localparam int CNT_W = $clog2(ERR_LIMIT + 1);
  localparam int WIN_W = $clog2(WINDOW_TICKS);

  logic [CNT_W-1:0] err_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             run_q;

  function automatic logic [MODE_W-1:0] load_mode(input logic [MODE_W-1:0] m, input logic serial);
    if (int'(m) > LAST)                  return MODE_W'(LAST);
    if (!serial && int'(m) < SATA_GENS)  return MODE_W'(SATA_GENS);
    return m;
  endfunction

  function automatic logic [MODE_W-1:0] step_mode(input logic [MODE_W-1:0] m, input logic serial);
    if (!serial && int'(m) < SATA_GENS) return MODE_W'(SATA_GENS);
    return m + MODE_W'(1);
  endfunction

  wire win_end  = time_tick && (win_cnt == WIN_W'(WINDOW_TICKS - 1));
  wire trig     = xfer_err && !win_end && (err_cnt == CNT_W'(ERR_LIMIT));
  wire at_floor = (int'(cur_mode) == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode   <= load_mode(boot_mode, sata_link);
      err_cnt    <= '0;
      win_cnt    <= '0;
      mode_req   <= 1'b0;
      floor_warn <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      mode_req <= 1'b0;
      if (trig) begin
        err_cnt <= '0;
        win_cnt <= '0;
        if (at_floor) floor_warn <= 1'b1;
        else begin
          cur_mode <= step_mode(cur_mode, sata_link);
          mode_req <= 1'b1;
        end
      end else if (win_end) begin
        win_cnt <= '0;
        err_cnt <= xfer_err ? CNT_W'(1) : '0;
      end else begin
        if (time_tick) win_cnt <= win_cnt + WIN_W'(1);
        if (xfer_err)  err_cnt <= err_cnt + CNT_W'(1);
      end
    end
  end

  initial begin
    p_params_ok: assert (ERR_LIMIT >= 1 && WINDOW_TICKS >= 2 && SATA_GENS >= 1 && UDMA_MODES >= 1);
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(err_cnt) <= ERR_LIMIT);

  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    mode_req |=> !mode_req);

  p_mode_moves_only_on_req_r4: assert property (@(posedge clk) disable iff (rst || !run_q)
    (cur_mode != $past(cur_mode)) |-> mode_req);

  p_mode_rises_r2: assert property (@(posedge clk) disable iff (rst || !run_q)
    mode_req |-> (cur_mode > $past(cur_mode)));

  p_floor_no_req_r8: assert property (@(posedge clk) disable iff (rst || !run_q)
    (int'($past(cur_mode)) == LAST) |-> !mode_req);

  p_warn_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    floor_warn |=> floor_warn);

  p_mode_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(cur_mode) <= LAST);
endmodule

// File: tb/sim_xfer_fallback.sv
`timescale 1ns/1ps
module sim_xfer_fallback;
  localparam int S = 2, U = 2, LIM = 2, WIN = 3;
  localparam int MW = 3;

  logic clk = 1'b0, rst = 1'b1, err = 1'b0, tick = 1'b0, sata = 1'b1;
  logic [MW-1:0] boot = '0;
  logic [MW-1:0] mode;
  logic req, warn;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xfer_fallback #(.SATA_GENS(S), .UDMA_MODES(U), .ERR_LIMIT(LIM), .WINDOW_TICKS(WIN)) u0 (
    .clk(clk), .rst(rst), .xfer_err(err), .time_tick(tick), .sata_link(sata),
    .boot_mode(boot), .cur_mode(mode), .mode_req(req), .floor_warn(warn));

  // {err, tick, mode[2:0], req, warn}; codes: 0,1 PHY gens, 2 UDMA1, 3 UDMA0, 4 PIO4, 5 PIO3
  localparam logic [6:0] VEC [25] = '{
    7'b1_0_000_0_0, 7'b1_0_000_0_0, 7'b1_0_001_1_0, 7'b0_0_001_0_0,
    7'b1_0_001_0_0, 7'b0_1_001_0_0, 7'b1_0_001_0_0, 7'b0_1_001_0_0,
    7'b0_1_001_0_0, 7'b1_0_001_0_0, 7'b1_0_001_0_0, 7'b1_0_010_1_0,
    7'b1_0_010_0_0, 7'b1_0_010_0_0, 7'b1_0_011_1_0, 7'b1_0_011_0_0,
    7'b1_0_011_0_0, 7'b1_0_100_1_0, 7'b1_0_100_0_0, 7'b1_0_100_0_0,
    7'b1_0_101_1_0, 7'b1_0_101_0_0, 7'b1_0_101_0_0, 7'b1_0_101_0_1,
    7'b0_0_101_0_1};

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic t);
    err = e; tick = t;
    @(negedge clk);
    err = 1'b0; tick = 1'b0;
  endtask

  task automatic do_reset(input logic [MW-1:0] b, input logic s);
    rst = 1'b1; boot = b; sata = s; err = 1'b0; tick = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int cyc_n = 0;
    while (!done) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc_n);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    do_reset(3'd0, 1'b1);
    chk("R1 mode", mode, 0); chk("R1 req", req, 0); chk("R1 warn", warn, 0);

    // R2 R3 R4 R5 R6 R7 R8: full walk down the ladder
    for (int i = 0; i < 25; i++) begin
      cyc(VEC[i][6], VEC[i][5]);
      chk($sformatf("R3/R4/R5/R7 vec%0d mode", i), mode, VEC[i][4:2]);
      chk($sformatf("R4/R8 vec%0d req", i), req, VEC[i][1]);
      chk($sformatf("R8 vec%0d warn", i), warn, VEC[i][0]);
    end

    // R10: reset mid-operation
    do_reset(3'd1, 1'b1);
    chk("R10 mode", mode, 1); chk("R10 warn", warn, 0);
    cyc(1, 0); cyc(1, 0);
    chk("R10 count cleared", mode, 1);

    // R1: out-of-range boot code clamps to PIO3
    do_reset(3'd7, 1'b1);
    chk("R1 clamp", mode, 5);
    // R1: PHY code on parallel link loads top UDMA
    do_reset(3'd0, 1'b0);
    chk("R1 parallel load", mode, 2);

    // R7: parallel link skips remaining PHY codes
    do_reset(3'd0, 1'b1);
    sata = 1'b0;
    cyc(1, 0); cyc(1, 0); cyc(1, 0);
    chk("R7 skip mode", mode, 2); chk("R7 skip req", req, 1);

    // R9: error coincides with window-closing tick
    do_reset(3'd0, 1'b1);
    cyc(0, 1); cyc(0, 1);
    cyc(1, 0); cyc(1, 0);
    cyc(1, 1);
    chk("R9 no trigger mode", mode, 0); chk("R9 no trigger req", req, 0);
    cyc(1, 0);
    chk("R9 second error mode", mode, 0);
    cyc(1, 0);
    chk("R9 trigger mode", mode, 1); chk("R9 trigger req", req, 1);

    // R6: count and window restart after downgrade
    cyc(0, 1); cyc(0, 1); cyc(1, 0); cyc(1, 0);
    chk("R6 no carry", mode, 1);
    cyc(1, 0);
    chk("R6 trigger", mode, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule